// File: doc/BRIEF.md
# Floppy Write Precompensation Unit

This block sits between a serial MFM write-data source and the head write driver of a floppy controller. It takes one encoded bit per bit cell and emits a write pulse for every 1. Each pulse can be moved earlier or later by a fixed number of ticks of an oversampling clock. The block runs on that oversampling clock and splits every bit cell into `TICKS` ticks. Once per cell it raises a strobe, and on that clock edge it takes the next bit from the source.

Captured bits move through a window that reaches `LOOK` cells into the past and `LOOK` cells into the future around the bit being written. For a 1 in the centre of the window, the block finds the gap to the nearest earlier transition and the gap to the nearest later one. When the later transition is closer, the pulse is written early. When the earlier transition is closer, the pulse is written late. When both are equal, the pulse stays at its nominal position. This works against the peak shift that pushes crowded flux transitions apart.

Shifting happens only while the inner-track flag is set. The same flag also drives a reduced-write-current output, which works on its own path and does not depend on the shifting.

Top module: `write_precomp`

## Requirements
- R1: `bit_strobe` is high for exactly one clock in every `TICKS` clocks. `wr_bit` is captured on the rising edge that ends a strobe cycle. That edge is the cell boundary.
- R2: Each captured 1 produces exactly one pulse, `PULSE` clocks wide. Each captured 0 produces none. The pulse for a bit appears in the cell that begins at the boundary capturing the `LOOK`-th bit after it.
- R3: A pulse at nominal position is high in clocks `TICKS/2+1` through `TICKS/2+PULSE` after its cell boundary. The clock right after the boundary is counted as 0.
- R4: The previous gap is the number of cells back to the nearest earlier 1 within `LOOK` cells. The next gap is the number of cells forward to the nearest later 1 within `LOOK` cells. A gap with no 1 in reach counts as `LOOK+1`.
- R5: With shifting enabled and next gap < previous gap, the pulse starts `SHIFT` clocks earlier than nominal (early).
- R6: With shifting enabled and next gap > previous gap, the pulse starts `SHIFT` clocks later than nominal (late).
- R7: With shifting enabled and equal gaps, the pulse is nominal.
- R8: With shifting disabled, every pulse is nominal whatever its neighbours are.
- R9: The shifting enable is sampled from `inner_track` at each cell boundary and holds for that whole cell. A change of `inner_track` in the middle of a cell does not change that cell's pulse.
- R10: `low_current` equals `inner_track` delayed by one clock, at any point in a cell.
- R11: `rst_n` low forces `wr_pulse` and `low_current` low at once. After reset, no pulse appears for bits captured before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `TICKS` clocks per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_bit | input | 1 | Encoded write bit, captured at the end of a strobe cycle |
| inner_track | input | 1 | Inner-track flag: enables shifting and reduced current |
| bit_strobe | output | 1 | High in the last clock of each cell; the source presents the next bit |
| wr_pulse | output | 1 | Write pulse train to the head driver |
| low_current | output | 1 | Reduced write current request |

## Verification
The hardest case to reach is the cell-by-cell relation between a bit and its pulse. The pulse for a bit appears only after `LOOK` more bits have been captured, and it takes its shifting enable from the boundary that starts its cell. The stimulus handles this by pushing whole seven-bit windows, each bit aligned to a strobe, and then reading the pulse position in the cell that follows. To test the enable sampling, the flag is changed right after that boundary. Reset is applied while a pulse is visibly high and the window is full of ones, so any leftover history would show up as a pulse after reset.

// File: rtl/precomp_pkg.sv
package precomp_pkg;
  typedef enum logic [1:0] {
    SH_NOMINAL = 2'd0,
    SH_EARLY   = 2'd1,
    SH_LATE    = 2'd2
  } shift_e;
endpackage

// File: rtl/wp_cell_timer.sv
module wp_cell_timer #(
  parameter int TICKS = 16,
  parameter int CW    = $clog2(TICKS) + 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST_T = CW'(TICKS - 1);

  logic [CW-1:0] cnt_d, cnt_q;

  assign last_o = (cnt_q == LAST_T);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (last_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wp_pattern_window.sv
module wp_pattern_window
  import precomp_pkg::*;
#(
  parameter int LOOK = 3
) (
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   shift_en_i,
  input  logic   bit_i,
  output logic   center_o,
  output shift_e dir_o
);
  localparam int WIN = 2 * LOOK + 1;
  localparam int DW  = $clog2(LOOK + 2);
  localparam logic [DW-1:0] FAR_D = DW'(LOOK + 1);

  logic [WIN-1:0]  win_d, win_q;
  logic [LOOK-1:0] prev_hit, next_hit;
  logic [DW-1:0]   prev_gap, next_gap;

  // index k-1 holds the neighbour k cells away from the centre
  for (genvar k = 1; k <= LOOK; k++) begin : g_hits
    assign prev_hit[k-1] = win_q[LOOK + k];
    assign next_hit[k-1] = win_q[LOOK - k];
  end

  always_comb begin
    prev_gap = FAR_D;
    next_gap = FAR_D;
    for (int k = LOOK; k >= 1; k--) begin
      if (prev_hit[k-1]) prev_gap = DW'(k);
      if (next_hit[k-1]) next_gap = DW'(k);
    end
  end

  always_comb begin
    if (next_gap < prev_gap)      dir_o = SH_EARLY;
    else if (next_gap > prev_gap) dir_o = SH_LATE;
    else                          dir_o = SH_NOMINAL;
  end

  assign center_o = win_q[LOOK];

  always_comb begin
    win_d = win_q;
    if (shift_en_i) win_d = {win_q[WIN-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end
endmodule

// File: rtl/wp_pulse_place.sv
module wp_pulse_place
  import precomp_pkg::*;
#(
  parameter int TICKS = 16,
  parameter int SHIFT = 1,
  parameter int PULSE = 2,
  parameter int CW    = $clog2(TICKS) + 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          cell_end_i,
  input  logic          inner_i,
  input  logic          center_i,
  input  shift_e        dir_i,
  output logic          en_o,
  output logic          pulse_o
);
  localparam logic [CW-1:0] NOM_T = CW'(TICKS / 2);
  localparam logic [CW-1:0] SH_T  = CW'(SHIFT);
  localparam logic [CW-1:0] PW_T  = CW'(PULSE);

  logic          en_d, en_q;
  logic          pulse_d, pulse_q;
  logic [CW-1:0] start_t, stop_t;

  always_comb begin
    en_d = en_q;
    if (cell_end_i) en_d = inner_i;
  end

  always_comb begin
    start_t = NOM_T;
    if (en_q) begin
      case (dir_i)
        SH_EARLY: start_t = NOM_T - SH_T;
        SH_LATE:  start_t = NOM_T + SH_T;
        default:  start_t = NOM_T;
      endcase
    end
    stop_t  = start_t + PW_T;
    pulse_d = center_i && (cnt_i >= start_t) && (cnt_i < stop_t);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      pulse_q <= pulse_d;
    end
  end

  assign en_o    = en_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/write_precomp.sv
module write_precomp
  import precomp_pkg::*;
#(
  parameter int TICKS = 16,
  parameter int LOOK  = 3,
  parameter int SHIFT = (TICKS + 6) / 12,
  parameter int PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_bit,
  input  logic inner_track,
  output logic bit_strobe,
  output logic wr_pulse,
  output logic low_current
);
  localparam int CW = $clog2(TICKS) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [CW-1:0] cnt_w;
  logic          cell_end_w;
  logic          center_w;
  shift_e        dir_w;
  logic          prec_en_w;
  logic          lowcur_q;

  // asynchronous assertion, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  wp_cell_timer #(.TICKS(TICKS), .CW(CW)) timer_i (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_w),
    .last_o (cell_end_w)
  );

  wp_pattern_window #(.LOOK(LOOK)) window_i (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .shift_en_i (cell_end_w),
    .bit_i      (wr_bit),
    .center_o   (center_w),
    .dir_o      (dir_w)
  );

  wp_pulse_place #(.TICKS(TICKS), .SHIFT(SHIFT), .PULSE(PULSE), .CW(CW)) place_i (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_w),
    .cell_end_i (cell_end_w),
    .inner_i    (inner_track),
    .center_i   (center_w),
    .dir_i      (dir_w),
    .en_o       (prec_en_w),
    .pulse_o    (wr_pulse)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) lowcur_q <= 1'b0;
    else         lowcur_q <= inner_track;
  end

  assign low_current = lowcur_q;
  assign bit_strobe  = cell_end_w;
endmodule

// File: rtl/wp_precomp_chk.sv
module wp_precomp_chk #(
  parameter int TICKS = 16,
  parameter int SHIFT = 1,
  parameter int PULSE = 2,
  parameter int CW    = $clog2(TICKS) + 1
) (
  input logic          clk,
  input logic          rst_ni,
  input logic [CW-1:0] cnt,
  input logic          bit_strobe,
  input logic          wr_pulse,
  input logic          center,
  input logic          prec_en,
  input logic          inner_track,
  input logic          low_current
);
  localparam logic [CW-1:0] WIN_LO = CW'(TICKS / 2 - SHIFT + 1);
  localparam logic [CW-1:0] WIN_HI = CW'(TICKS / 2 + SHIFT + PULSE);
  localparam logic [CW-1:0] NOM_LO = CW'(TICKS / 2 + 1);
  localparam logic [CW-1:0] NOM_HI = CW'(TICKS / 2 + PULSE);

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_strobe |=> !bit_strobe);

  p_pulse_needs_one_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_pulse |-> center);

  if (PULSE > 1) begin : g_width
    p_pulse_min_width_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      $rose(wr_pulse) |=> wr_pulse);
  end

  p_pulse_window_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_pulse |-> (cnt >= WIN_LO && cnt <= WIN_HI));

  p_nominal_when_off_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_pulse && !prec_en) |-> (cnt >= NOM_LO && cnt <= NOM_HI));

  p_enable_held_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(bit_strobe) |-> $stable(prec_en));

  p_lowcur_follow_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |-> (low_current == $past(inner_track)));
endmodule

bind write_precomp wp_precomp_chk #(
  .TICKS(TICKS), .SHIFT(SHIFT), .PULSE(PULSE), .CW(CW)
) chk_i (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .cnt         (cnt_w),
  .bit_strobe  (bit_strobe),
  .wr_pulse    (wr_pulse),
  .center      (center_w),
  .prec_en     (prec_en_w),
  .inner_track (inner_track),
  .low_current (low_current)
);

// File: tb/write_precomp_tb_top.sv
`timescale 1ns/1ps
module write_precomp_tb_top;
  localparam int TICKS = 16;
  localparam int LOOK  = 3;
  localparam int SHIFT = (TICKS + 6) / 12;
  localparam int PULSE = 2;
  localparam int NOM   = TICKS / 2;
  localparam int NVEC  = 14;
  localparam int LIMIT = 100000;

  // {inner_track, window pushed oldest first, expected: 0 none 1 nominal 2 early 3 late}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 7'b0001000, 2'd1},
    {1'b1, 7'b0001010, 2'd2},
    {1'b1, 7'b0101000, 2'd3},
    {1'b1, 7'b0101010, 2'd1},
    {1'b1, 7'b1001010, 2'd2},
    {1'b1, 7'b0101001, 2'd3},
    {1'b1, 7'b0000000, 2'd0},
    {1'b1, 7'b1110111, 2'd0},
    {1'b1, 7'b0011100, 2'd1},
    {1'b1, 7'b0011000, 2'd3},
    {1'b1, 7'b0001100, 2'd2},
    {1'b0, 7'b0001010, 2'd1},
    {1'b0, 7'b0101000, 2'd1},
    {1'b1, 7'b1001001, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n, wr_bit, inner_track;
  logic bit_strobe, wr_pulse, low_current;
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   done   = 0;

  always #2.5 clk = ~clk;

  write_precomp #(.TICKS(TICKS), .LOOK(LOOK), .SHIFT(SHIFT), .PULSE(PULSE)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_bit      (wr_bit),
    .inner_track (inner_track),
    .bit_strobe  (bit_strobe),
    .wr_pulse    (wr_pulse),
    .low_current (low_current)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    wr_bit = b;
    while (!bit_strobe) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_window(input logic [6:0] w);
    for (int i = 6; i >= 0; i--) push_bit(w[i]);
  endtask

  // starts at the negedge right after a cell boundary
  task automatic scan_cell(output int first, output int width);
    wr_bit = 1'b0;
    first  = -1;
    width  = 0;
    for (int j = 0; j < TICKS; j++) begin
      if (wr_pulse) begin
        if (first < 0) first = j;
        width++;
      end
      @(negedge clk);
    end
  endtask

  function automatic int exp_first(input int code);
    case (code)
      2: return NOM + 1 - SHIFT;
      3: return NOM + 1 + SHIFT;
      default: return NOM + 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int first, width, n;
    rst_n = 1'b0; wr_bit = 1'b0; inner_track = 1'b0;
    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11 reset wr_pulse", wr_pulse, 0);
    check("R11 reset low_current", low_current, 0);
    check("R1 reset bit_strobe", bit_strobe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      inner_track = VEC[v][9];
      push_window(VEC[v][8:2]);
      scan_cell(first, width);
      if (VEC[v][1:0] == 2'd0) begin
        check($sformatf("R2 vec%0d no pulse width", v), width, 0);
      end else begin
        check($sformatf("R5 R6 R7 R8 vec%0d pulse start", v), first, exp_first(VEC[v][1:0]));
        check($sformatf("R2 vec%0d pulse width", v), width, PULSE);
      end
    end

    // R9: flag raised mid-cell does not shift this cell
    inner_track = 1'b0;
    push_window(7'b0001010);
    inner_track = 1'b1;
    scan_cell(first, width);
    check("R9 late enable stays nominal", first, NOM + 1);
    // R9: flag dropped mid-cell keeps the shift
    inner_track = 1'b1;
    push_window(7'b0001010);
    inner_track = 1'b0;
    scan_cell(first, width);
    check("R9 early kept after flag drop", first, NOM + 1 - SHIFT);

    // R10: one-clock follow, mid-cell
    @(negedge clk); @(negedge clk);
    inner_track = 1'b1;
    check("R10 low_current before edge", low_current, 0);
    @(negedge clk);
    check("R10 low_current after rise", low_current, 1);
    inner_track = 1'b0;
    @(negedge clk);
    check("R10 low_current after fall", low_current, 0);

    // R1: strobe spacing and width
    while (!bit_strobe) @(negedge clk);
    @(negedge clk);
    check("R1 strobe one clock", bit_strobe, 0);
    n = 1;
    while (!bit_strobe) begin @(negedge clk); n++; end
    check("R1 strobe period", n, TICKS);
    @(negedge clk);

    // R11: reset during a visible pulse, history must be gone
    inner_track = 1'b1;
    push_window(7'b1111111);
    wr_bit = 1'b0;
    for (int j = 0; j <= NOM; j++) @(negedge clk);
    check("R3 pulse high before reset", wr_pulse, 1);
    rst_n = 1'b0;
    #1;
    check("R11 async clear wr_pulse", wr_pulse, 0);
    check("R11 async clear low_current", low_current, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int j = 0; j < 5 * TICKS; j++) begin
      @(negedge clk);
      if (wr_pulse) n++;
    end
    check("R11 no pulses from old history", n, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule